// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block conditions the second ALU operand in the same cycle as the ALU operation. It takes a data word, a shift kind, a shift distance and the current carry flag. It returns the shifted word and the carry that the flag logic should record. The carry is the last bit pushed out of the word, or the old carry when nothing moves.

There are five shift kinds: logical left, logical right, arithmetic right, rotate right, and a one-position rotate right through the carry flag. The block has no clock and no storage. It is a logarithmic cascade of stages over a funnel word that is 2·DATA_W+1 bits wide. The incoming carry sits at the bottom of the funnel, so the carry-out falls out of the same path as the result. A left shift is done as a right shift of the bit-reversed operand.

Top module: `barrel_shifter`

## Requirements
- R1: Kind code 0 (logical left) by y in 1..31 gives operand << y, with zeros in the y vacated low bits.
- R2: For kind code 0 with y in 1..31, carry_o equals bit (32 − y) of the operand. Example: 0x80000004 shifted by 1 gives 0x00000008 with carry 1.
- R3: Kind code 1 (logical right) by y in 1..31 gives operand >> y, with zeros in the y vacated high bits.
- R4: Kind code 2 (arithmetic right) by y in 1..31 fills the y vacated high bits with copies of operand bit 31.
- R5: Kind code 3 (rotate right) by y in 1..31 moves operand bit i to bit (i − y) mod 32 and loses no bit.
- R6: For kind codes 1, 2 and 3 with y in 1..31, carry_o equals operand bit (y − 1).
- R7: Kind code 4 (rotate right through carry) ignores amount_i. result_o is {carry_i, operand[31:1]} and carry_o is operand bit 0.
- R8: For kind codes 0 to 3 with amount 0, result_o equals the operand and carry_o equals carry_i.
- R9: Kind codes 5, 6 and 7 pass the operand and carry_i through unchanged, whatever the amount.
- R10: For every kind, a shift by y gives the same value and carry as y successive shifts by one. A left shift of 5 by 2 gives 20.
- R11: The outputs depend only on the present inputs. They settle within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | DATA_W (32) | Word to be shifted |
| kind_i | input | 3 | Shift kind code (0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate through carry, 5..7 pass) |
| amount_i | input | AMT_W (5) | Shift distance 0..31 |
| carry_i | input | 1 | Current carry flag |
| result_o | output | DATA_W (32) | Shifted word |
| carry_o | output | 1 | Carry produced by the shift |

## Verification
The result word and the carry-out come from one funnel path in the same evaluation, so a single input change must get both right together. The bench covers every kind code, every amount and both carry values, over a mix of fixed edge patterns and pseudo-random words. It judges each output against a model that applies y single-position steps. Two cases test the shared carry path hardest: amount 0, where the carry must come straight from carry_i, and the through-carry rotate, where carry_i enters the top of the word while operand bit 0 leaves as carry.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  localparam logic [2:0] KIND_LSL = 3'd0;
  localparam logic [2:0] KIND_LSR = 3'd1;
  localparam logic [2:0] KIND_ASR = 3'd2;
  localparam logic [2:0] KIND_ROR = 3'd3;
  localparam logic [2:0] KIND_RRX = 3'd4;
endpackage

// File: rtl/bshift_prep.sv
module bshift_prep
  import bshift_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic [W-1:0]  operand_i,
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] amount_i,
  input  logic          carry_i,
  output logic [2*W:0]  funnel_o,
  output logic [AW-1:0] amt_o,
  output logic          rev_o
);
  logic [W-1:0] op_rev;
  logic [W-1:0] lo;
  logic [W-1:0] hi;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign op_rev[i] = operand_i[W-1-i];
  end

  always_comb begin
    rev_o = 1'b0;
    amt_o = amount_i;
    lo    = operand_i;
    hi    = '0;
    unique case (kind_i)
      KIND_LSL: begin
        rev_o = 1'b1;
        lo    = op_rev;
      end
      KIND_LSR: hi = '0;
      KIND_ASR: hi = {W{operand_i[W-1]}};
      KIND_ROR: hi = operand_i;
      KIND_RRX: begin
        hi    = {{(W-1){1'b0}}, carry_i};
        amt_o = AW'(1);
      end
      default: amt_o = '0;
    endcase
    funnel_o = {hi, lo, carry_i};
  end
endmodule

// File: rtl/bshift_stage.sv
module bshift_stage #(
  parameter int WF = 65,
  parameter int SH = 1
) (
  input  logic [WF-1:0] d_i,
  input  logic          en_i,
  output logic [WF-1:0] q_o
);
  assign q_o = en_i ? (d_i >> SH) : d_i;
endmodule

// File: rtl/bshift_finish.sv
module bshift_finish #(
  parameter int W = 32
) (
  input  logic [2*W:0]  funnel_i,
  input  logic          rev_i,
  output logic [W-1:0]  result_o,
  output logic          carry_o
);
  logic [W-1:0] win;
  logic [W-1:0] win_rev;
  logic         unused_top;

  assign win        = funnel_i[W:1];
  assign unused_top = ^funnel_i[2*W:W+1];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign win_rev[i] = win[W-1-i];
  end

  assign result_o = rev_i ? win_rev : win;
  assign carry_o  = funnel_i[0] | (unused_top & 1'b0);
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W),
  localparam int FUN_W = 2*DATA_W + 1
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [2:0]        kind_i,
  input  logic [AMT_W-1:0]  amount_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  logic [FUN_W-1:0] chain [AMT_W+1];
  logic [AMT_W-1:0] amt;
  logic             rev;

  bshift_prep #(.W(DATA_W), .AW(AMT_W)) u_prep (
    .operand_i (operand_i),
    .kind_i    (kind_i),
    .amount_i  (amount_i),
    .carry_i   (carry_i),
    .funnel_o  (chain[0]),
    .amt_o     (amt),
    .rev_o     (rev)
  );

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    bshift_stage #(.WF(FUN_W), .SH(1 << s)) u_stage (
      .d_i  (chain[s]),
      .en_i (amt[s]),
      .q_o  (chain[s+1])
    );
  end

  bshift_finish #(.W(DATA_W)) u_finish (
    .funnel_i (chain[AMT_W]),
    .rev_i    (rev),
    .result_o (result_o),
    .carry_o  (carry_o)
  );
endmodule

// File: rtl/barrel_shifter_checker.sv
module barrel_shifter_checker #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input logic [W-1:0]  operand_i,
  input logic [2:0]    kind_i,
  input logic [AW-1:0] amount_i,
  input logic          carry_i,
  input logic [W-1:0]  result_o,
  input logic          carry_o
);
  int unsigned a;

  always_comb begin
    a = int'(amount_i);
    if (kind_i <= 3'd3 && a == 0) begin
      assert_zero_pass_R8: assert (result_o == operand_i && carry_o == carry_i);
    end
    if (kind_i == 3'd0 && a != 0) begin
      assert_lsl_carry_R2: assert (carry_o == operand_i[W-a]);
      assert_lsl_fill_R1: assert (result_o[0] == 1'b0);
    end
    if ((kind_i == 3'd1 || kind_i == 3'd2 || kind_i == 3'd3) && a != 0) begin
      assert_right_carry_R6: assert (carry_o == operand_i[a-1]);
    end
    if (kind_i == 3'd1 && a != 0) begin
      assert_lsr_fill_R3: assert (result_o[W-1] == 1'b0);
    end
    if (kind_i == 3'd2) begin
      assert_asr_sign_R4: assert (result_o[W-1] == operand_i[W-1]);
    end
    if (kind_i == 3'd3) begin
      assert_ror_bits_R5: assert ($countones(result_o) == $countones(operand_i));
    end
    if (kind_i == 3'd4) begin
      assert_rrx_shape_R7: assert (result_o[W-1] == carry_i && carry_o == operand_i[0]
                                   && result_o[W-2:0] == operand_i[W-1:1]);
    end
    if (kind_i >= 3'd5) begin
      assert_undef_pass_R9: assert (result_o == operand_i && carry_o == carry_i);
    end
  end
endmodule

bind barrel_shifter barrel_shifter_checker #(.W(DATA_W), .AW(AMT_W)) u_chk (
  .operand_i (operand_i),
  .kind_i    (kind_i),
  .amount_i  (amount_i),
  .carry_i   (carry_i),
  .result_o  (result_o),
  .carry_o   (carry_o)
);

// File: tb/barrel_shifter_tb.sv
`timescale 1ns/1ps
module barrel_shifter_tb;
  localparam int W  = 32;
  localparam int AW = 5;

  logic          clk;
  logic          rst_ni;
  logic [W-1:0]  operand;
  logic [2:0]    kind;
  logic [AW-1:0] amount;
  logic          cin;
  logic [W-1:0]  result;
  logic          cout;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  barrel_shifter #(.DATA_W(W)) u_dut (
    .operand_i (operand),
    .kind_i    (kind),
    .amount_i  (amount),
    .carry_i   (cin),
    .result_o  (result),
    .carry_o   (cout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // one-position steps, repeated y times (R10 model)
  task automatic model(input logic [W-1:0] v_in, input logic [2:0] k, input int y,
                       input logic c_in, output logic [W-1:0] v, output logic c);
    v = v_in;
    c = c_in;
    if (k == 3'd4) begin
      c = v_in[0];
      v = {c_in, v_in[W-1:1]};
    end else if (k <= 3'd3) begin
      for (int n = 0; n < y; n++) begin
        case (k)
          3'd0: begin c = v[W-1]; v = v << 1; end
          3'd1: begin c = v[0];   v = v >> 1; end
          3'd2: begin c = v[0];   v = {v[W-1], v[W-1:1]}; end
          default: begin c = v[0]; v = {v[0], v[W-1:1]}; end
        endcase
      end
    end
  endtask

  function automatic string tag_val(input logic [2:0] k, input int y);
    if (k >= 3'd5) return "R9";
    if (k == 3'd4) return "R7";
    if (y == 0)    return "R8";
    case (k)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic string tag_car(input logic [2:0] k, input int y);
    if (k >= 3'd5) return "R9";
    if (k == 3'd4) return "R7";
    if (y == 0)    return "R8";
    if (k == 3'd0) return "R2";
    return "R6";
  endfunction

  task automatic apply(input logic [W-1:0] v, input logic [2:0] k, input int y, input logic c);
    logic [W-1:0] ev;
    logic         ec;
    @(posedge clk);
    operand = v; kind = k; amount = AW'(y); cin = c;
    model(v, k, y, c, ev, ec);
    @(negedge clk);
    checks++;
    if (result !== ev) begin
      errors++;
      $display("FAIL %s value kind=%0d amt=%0d op=%h cin=%b: got %h exp %h",
               tag_val(k, y), k, y, v, c, result, ev);
    end
    checks++;
    if (cout !== ec) begin
      errors++;
      $display("FAIL %s carry kind=%0d amt=%0d op=%h cin=%b: got %b exp %b",
               tag_car(k, y), k, y, v, c, cout, ec);
    end
  endtask

  task automatic expect_eq(input string req, input logic [W-1:0] gv, input logic [W-1:0] xv,
                           input logic gc, input logic xc);
    checks++;
    if (gv !== xv || gc !== xc) begin
      errors++;
      $display("FAIL %s got %h/%b exp %h/%b", req, gv, gc, xv, xc);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] pats [8];
    logic [W-1:0] lfsr;
    logic [W-1:0] r1v;
    logic         r1c;
    rst_ni = 1'b0;
    operand = '0; kind = '0; amount = '0; cin = 1'b0;
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8000_0000; pats[3] = 32'h0000_0001;
    pats[4] = 32'h8000_0004; pats[5] = 32'h5555_5555;
    pats[6] = 32'h7FFF_FFFE; pats[7] = 32'h1234_5678;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // idle state: zero in, zero out (R8)
    @(negedge clk);
    expect_eq("R8 idle", result, 32'h0, cout, 1'b0);

    // directed examples (R2, R10)
    apply(32'h8000_0004, 3'd0, 1, 1'b0);
    expect_eq("R2 0x80000004<<1", result, 32'h0000_0008, cout, 1'b1);
    apply(32'd5, 3'd0, 2, 1'b0);
    expect_eq("R10 5<<2", result, 32'd20, cout, 1'b0);

    // R10: shift by 3 equals three hardware shifts by one
    for (int k = 0; k < 4; k++) begin
      r1v = 32'hC001_D00D; r1c = 1'b0;
      for (int n = 0; n < 3; n++) begin
        @(posedge clk);
        operand = r1v; kind = 3'(k); amount = AW'(1); cin = r1c;
        @(negedge clk);
        r1v = result; r1c = cout;
      end
      @(posedge clk);
      operand = 32'hC001_D00D; kind = 3'(k); amount = AW'(3); cin = 1'b0;
      @(negedge clk);
      expect_eq("R10 three-step", result, r1v, cout, r1c);
    end

    // R11: outputs follow inputs between clock edges
    @(negedge clk);
    operand = 32'h0000_00F0; kind = 3'd1; amount = AW'(4); cin = 1'b0;
    #1;
    expect_eq("R11 comb", result, 32'h0000_000F, cout, 1'b0);

    // near-exhaustive sweep: R1..R9
    lfsr = 32'hACE1_2468;
    for (int p = 0; p < 24; p++) begin
      logic [W-1:0] v;
      if (p < 8) v = pats[p];
      else begin
        lfsr = {lfsr[W-2:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        v = lfsr;
      end
      for (int k = 0; k < 8; k++)
        for (int y = 0; y < 32; y++)
          for (int c = 0; c < 2; c++)
            apply(v, 3'(k), y, c[0]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule